// File: doc/BRIEF.md
# Serial Debug Port Acknowledge and Sticky-Error Controller

This block chooses the acknowledge for every request that reaches a two-wire serial debug port once the request header has been decoded. It sees the selected register (identification, control/status, abort, or the access port), the direction, write data for the abort and control/status registers, and a completion strobe from the downstream access port. One cycle after each request it returns OK, WAIT or FAULT. It also says whether a data phase follows and supplies read data for the local registers.

The block keeps three sticky error flags and an overrun-detect enable. Two flags are set by the access port. The third, overrun, is set by the block itself when it has to answer WAIT while overrun detection is on. While any flag is set, every access-port request is refused with FAULT. The local registers stay reachable, so a debugger can stream a block of transfers, read the status register at the end and clear the flags through the abort register. The same abort register can pulse a terminate request to the access port. That pulse also releases the port, so the next request is not held back by the abandoned transfer.

Top module: `dbg_ack_ctrl`

## Requirements
- R1: One cycle after a cycle with `req_valid` high, `ack_valid` is high and `ack` carries exactly one code: OK = 3'b001, WAIT = 3'b010, FAULT = 3'b100. In every other cycle `ack_valid` is low and `ack` is 3'b000.
- R2: A request to the access port (`req_sel` = 2'd3) made while an earlier access-port transfer is still outstanding, with no sticky flag set, is answered WAIT and is not forwarded.
- R3: When such a WAIT is given while overrun detection is enabled, the sticky overrun flag (status bit 1) becomes 1.
- R4: While any sticky flag is set, every access-port request is answered FAULT, is not forwarded and leaves the flags unchanged.
- R5: Requests to identification (2'd0), control/status (2'd1) and abort (2'd2) are always answered OK, whatever the flags and the outstanding state.
- R6: `data_phase` is high with every OK. With WAIT or FAULT it equals the overrun-detect enable.
- R7: An identification read returns `IDENT_VAL`. A control/status read returns the enable at bit 0, overrun at bit 1, compare at bit 4 and error at bit 5, with all other bits 0.
- R8: A control/status write loads the overrun-detect enable from write bit 0 and never alters a sticky flag.
- R9: `set_cmp` and `set_err` set the compare and error flags. An abort write clears compare with bit 1, error with bit 2 and overrun with bit 4, and ignores its other bits. No other event clears a flag. A set in the same cycle as its clear leaves the flag set.
- R10: An abort write with bit 0 set gives a one-cycle `ap_abort` pulse, aligned with its acknowledge, and ends the outstanding state, so the next access-port request is not answered WAIT.
- R11: An access-port request answered OK gives a one-cycle `ap_req` pulse aligned with its acknowledge and makes a transfer outstanding. `ap_done` ends it, and a new issue in the same cycle as `ap_done` keeps it outstanding.
- R12: After reset the flags, the enable and the outstanding state are 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A decoded request is present this cycle |
| req_sel | input | 2 | Target: 0 identification, 1 control/status, 2 abort, 3 access port |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data for control/status and abort |
| ap_done | input | 1 | Access port finished its outstanding transfer |
| set_cmp | input | 1 | Access port raises the sticky compare flag |
| set_err | input | 1 | Access port raises the sticky error flag |
| ack_valid | output | 1 | Acknowledge present this cycle |
| ack | output | 3 | One-hot acknowledge code |
| data_phase | output | 1 | A data phase follows the acknowledge |
| rd_data | output | DW | Read data for local registers |
| ap_req | output | 1 | Forward the request to the access port |
| ap_abort | output | 1 | Terminate the access port's current transfer |

## Verification
Two pairs of functions can land in the same cycle. In the first, an abort write that clears a flag arrives in the cycle where the access port raises that same flag. In the second, a new access-port issue coincides with `ap_done` for the previous transfer. Directed steps force both collisions. Random traffic, with frequent abort writes and strobes, produces many more. A bench model applies set-over-clear and issue-over-completion, and its verdict is judged through the next status read and the next access-port acknowledge.

// File: rtl/dbg_ack_ctrl.sv
module dbg_ack_ctrl #(
  parameter int DW = 32,
  parameter logic [DW-1:0] IDENT_VAL = 'h0C0F_FEE5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_sel,
  input  logic          req_wr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ap_done,
  input  logic          set_cmp,
  input  logic          set_err,
  output logic          ack_valid,
  output logic [2:0]    ack,
  output logic          data_phase,
  output logic [DW-1:0] rd_data,
  output logic          ap_req,
  output logic          ap_abort
);
  localparam logic [2:0] ACK_OK = 3'b001, ACK_WAIT = 3'b010, ACK_FAULT = 3'b100;
  localparam logic [1:0] SEL_ID = 2'd0, SEL_CS = 2'd1, SEL_ABT = 2'd2, SEL_AP = 2'd3;
  localparam int B_EN = 0, B_ORUN = 1, B_CMP = 4, B_ERR = 5;
  localparam int A_KILL = 0, A_CCMP = 1, A_CERR = 2, A_CORUN = 4;

  logic orun_en_q, f_orun_q, f_cmp_q, f_err_q, inflight_q;
  logic [2:0] ack_d;
  logic [DW-1:0] cs_word, rd_d;

  wire sticky   = f_orun_q | f_cmp_q | f_err_q;
  wire to_ap    = req_valid && req_sel == SEL_AP;
  wire ap_fault = to_ap && sticky;
  wire ap_wait  = to_ap && !sticky && inflight_q;
  wire ap_go    = to_ap && !sticky && !inflight_q;
  wire abt_wr   = req_valid && req_wr && req_sel == SEL_ABT;
  wire cs_wr    = req_valid && req_wr && req_sel == SEL_CS;
  wire kill     = abt_wr && req_wdata[A_KILL];

  always_comb begin
    cs_word = '0;
    cs_word[B_EN]   = orun_en_q;
    cs_word[B_ORUN] = f_orun_q;
    cs_word[B_CMP]  = f_cmp_q;
    cs_word[B_ERR]  = f_err_q;
  end

  always_comb begin
    ack_d = 3'b000;
    if (req_valid) ack_d = ap_fault ? ACK_FAULT : ap_wait ? ACK_WAIT : ACK_OK;
  end

  always_comb begin
    rd_d = '0;
    if (req_valid && !req_wr) begin
      if (req_sel == SEL_ID) rd_d = IDENT_VAL;
      else if (req_sel == SEL_CS) rd_d = cs_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orun_en_q  <= 1'b0;
      f_orun_q   <= 1'b0;
      f_cmp_q    <= 1'b0;
      f_err_q    <= 1'b0;
      inflight_q <= 1'b0;
      ack_valid  <= 1'b0;
      ack        <= 3'b000;
      data_phase <= 1'b0;
      rd_data    <= '0;
      ap_req     <= 1'b0;
      ap_abort   <= 1'b0;
    end else begin
      if (cs_wr) orun_en_q <= req_wdata[B_EN];
      f_orun_q <= (ap_wait && orun_en_q) || (f_orun_q && !(abt_wr && req_wdata[A_CORUN]));
      f_cmp_q  <= set_cmp || (f_cmp_q && !(abt_wr && req_wdata[A_CCMP]));
      f_err_q  <= set_err || (f_err_q && !(abt_wr && req_wdata[A_CERR]));
      if (ap_go) inflight_q <= 1'b1;
      else if (kill || ap_done) inflight_q <= 1'b0;
      ack_valid  <= req_valid;
      ack        <= ack_d;
      data_phase <= req_valid && (ack_d == ACK_OK || orun_en_q);
      rd_data    <= rd_d;
      ap_req     <= ap_go;
      ap_abort   <= kill;
    end
  end

  a_r1_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $onehot(ack));
  a_r1_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |-> ack == 3'b000);
  a_r3_orun_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_orun_q) |-> ack_valid && ack == ACK_WAIT);
  a_r5_local_never_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack != ACK_OK) |-> $past(req_sel) == SEL_AP);
  a_r6_dphase_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack != ACK_OK) |-> data_phase == orun_en_q);
  a_r9_orun_clear_only_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_orun_q) |-> $past(abt_wr && req_wdata[A_CORUN]));
  a_r10_abort_frees: assert property (@(posedge clk) disable iff (!rst_n)
    ap_abort |-> !inflight_q);
  a_r11_issue_marks: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req |-> inflight_q && ack == ACK_OK);
endmodule

// File: tb/dbg_ack_ctrl_test.sv
module dbg_ack_ctrl_test;
  localparam int DW = 32;
  localparam logic [DW-1:0] IDV = 'h0C0F_FEE5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_wr = 0, ap_done = 0, set_cmp = 0, set_err = 0;
  logic [1:0] req_sel = 0;
  logic [DW-1:0] req_wdata = 0;
  logic ack_valid, data_phase, ap_req, ap_abort;
  logic [2:0] ack;
  logic [DW-1:0] rd_data;

  dbg_ack_ctrl #(.DW(DW), .IDENT_VAL(IDV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_wr(req_wr), .req_wdata(req_wdata), .ap_done(ap_done),
    .set_cmp(set_cmp), .set_err(set_err), .ack_valid(ack_valid), .ack(ack),
    .data_phase(data_phase), .rd_data(rd_data), .ap_req(ap_req), .ap_abort(ap_abort));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit m_en, m_fo, m_fc, m_fe, m_inf;
  bit e_v, e_dp, e_req, e_abt, e_rdchk;
  logic [2:0] e_ack;
  logic [1:0] e_sel;
  logic [DW-1:0] e_rd;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] cs_exp();
    logic [DW-1:0] w = '0;
    w[0] = m_en; w[1] = m_fo; w[4] = m_fc; w[5] = m_fe;
    return w;
  endfunction

  function automatic string ack_tag(logic [2:0] a, logic [1:0] s);
    if (s != 2'd3) return "R5";
    if (a == 3'b010) return "R2";
    if (a == 3'b100) return "R4";
    return "R11";
  endfunction

  task automatic compare();
    chk("R1 ack_valid", ack_valid, e_v);
    if (e_v) chk(ack_tag(e_ack, e_sel), ack, e_ack);
    else chk("R1 ack idle", ack, 3'b000);
    chk("R6 data_phase", data_phase, e_dp);
    chk("R11 ap_req", ap_req, e_req);
    chk("R10 ap_abort", ap_abort, e_abt);
    if (e_rdchk) begin
      if (e_sel == 2'd0) chk("R7 ident", rd_data, e_rd);
      else begin
        chk("R8 enable bit", rd_data[0], e_rd[0]);
        chk("R3 overrun bit", rd_data[1], e_rd[1]);
        chk("R9 cmp/err bits", {rd_data[5], rd_data[4]}, {e_rd[5], e_rd[4]});
        chk("R7 spare bits", {rd_data[DW-1:6], rd_data[3:2]}, {e_rd[DW-1:6], e_rd[3:2]});
      end
    end
  endtask

  task automatic step(bit v, logic [1:0] s, bit w, logic [DW-1:0] d, bit dn, bit sc, bit se);
    bit sticky, aw, setfo;
    @(negedge clk);
    compare();
    req_valid = v; req_sel = s; req_wr = w; req_wdata = d;
    ap_done = dn; set_cmp = sc; set_err = se;
    sticky = m_fo | m_fc | m_fe;
    e_v = v; e_sel = s; e_ack = 3'b000; e_req = 0; setfo = 0;
    if (v) begin
      if (s != 2'd3) e_ack = 3'b001;
      else if (sticky) e_ack = 3'b100;
      else if (m_inf) begin e_ack = 3'b010; setfo = m_en; end
      else begin e_ack = 3'b001; e_req = 1; end
    end
    e_dp = v && (e_ack == 3'b001 || m_en);
    e_rdchk = v && !w && s <= 2'd1;
    e_rd = (s == 2'd0) ? IDV : cs_exp();
    aw = v && w && s == 2'd2;
    e_abt = aw && d[0];
    if (v && w && s == 2'd1) m_en = d[0];
    m_fo = setfo || (m_fo && !(aw && d[4]));
    m_fc = sc || (m_fc && !(aw && d[1]));
    m_fe = se || (m_fe && !(aw && d[2]));
    if (e_req) m_inf = 1;
    else if (e_abt || dn) m_inf = 0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R12: outputs idle straight after reset
    chk("R12 reset outputs", {ack_valid, ack, data_phase, ap_req, ap_abort, rd_data}, '0);
    step(1, 2'd1, 0, 0, 0, 0, 0);            // R12 status reads zero
    step(1, 2'd0, 0, 0, 0, 0, 0);            // R7 ident
    step(1, 2'd3, 0, 0, 0, 0, 0);            // R11 issue
    step(1, 2'd3, 0, 0, 0, 0, 0);            // R2 WAIT, no data phase
    step(1, 2'd1, 1, 32'h1, 0, 0, 0);        // R8 enable overrun
    step(1, 2'd3, 1, 0, 0, 0, 0);            // R3 WAIT sets overrun
    step(1, 2'd3, 0, 0, 0, 0, 0);            // R4 FAULT with data phase
    step(1, 2'd1, 0, 0, 0, 0, 0);            // R3 overrun visible
    step(1, 2'd1, 1, 32'h0, 0, 0, 0);        // R8 write does not clear
    step(1, 2'd0, 0, 0, 0, 0, 0);            // R5 local OK while sticky
    step(1, 2'd2, 1, 32'h11, 0, 0, 0);       // R10 abort + clear overrun
    step(1, 2'd3, 0, 0, 0, 0, 0);            // R10 next AP request OK
    step(1, 2'd2, 1, 32'h4, 0, 0, 1);        // R9 set wins over clear
    step(1, 2'd1, 0, 0, 0, 0, 0);
    step(1, 2'd3, 0, 0, 0, 0, 0);            // R4 FAULT from error flag
    step(1, 2'd2, 1, 32'h6, 0, 0, 0);        // R9 clear error
    step(1, 2'd3, 0, 0, 1, 0, 0);            // R11 WAIT, done this cycle
    step(1, 2'd3, 0, 0, 0, 0, 0);            // R11 issue
    step(1, 2'd3, 0, 0, 1, 0, 0);            // R2 WAIT while done arrives
    step(1, 2'd3, 0, 0, 1, 0, 0);            // R11 issue with done same cycle
    step(1, 2'd3, 0, 0, 0, 0, 0);            // R11 still outstanding: WAIT
    step(0, 2'd0, 0, 0, 0, 0, 0);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic [DW-1:0] d = $urandom;
      step($urandom_range(0, 9) < 7, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           d, $urandom_range(0, 9) < 2, $urandom_range(0, 49) == 0, $urandom_range(0, 49) == 0);
    end
    step(0, 2'd0, 0, 0, 0, 0, 0);
    step(0, 2'd0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule